// File: doc/BRIEF.md
# Status Change Notification and Interrupt Bank

This block watches a vector of live condition flags coming from monitors elsewhere on the chip. Typical flags are configuration load finished, configuration checksum failure, loss of an input clock, clock loss combined with frequency drift, loss of lock per loop, and holdover per loop. The holdover flags are packed one per loop in loop order, the first loop at bit 0. Each flag passes through a multi-flop synchronizer. Any change of the synchronized value, rising or falling, sets a sticky change bit. An enable bit per flag decides whether that sticky bit pulls down a shared active-low interrupt line.

Software reaches the block through a plain register port with a combinational read path. The flags are grouped into 8-bit registers. Three windows of these registers exist, one after another: live values first, then sticky change bits, then enables. Software finds the cause of an interrupt by reading the change bits. It acknowledges by writing ones to the bits it has handled, and it can silence a source by clearing its enable. All enables come out of reset set, so every source can interrupt from the start.

Top module: `stat_notify_bank`

## Requirements
- R1: Source k appears in the live window at address k/8, bit k%8, two clock edges after it is sampled on `status_in`. Addresses 0..3 form the live window.
- R2: When the synchronized value of source k differs from its value one edge earlier, change bit k is set on the next edge. Both rising and falling changes count. Change bits are read at addresses 4..7, same bit layout.
- R3: A change bit stays set until software writes a 1 to it at its change address. Writing 0 to a change bit leaves it unchanged.
- R4: A new change of source k in the same cycle as a write that clears change bit k leaves the bit set.
- R5: Enable bits are read and written at addresses 8..11, same bit layout. After reset every enable bit reads 1 (0xFF per register).
- R6: `irq_n` is 0 exactly when some source has both its change bit and its enable bit at 1, and 1 otherwise. It follows the register state in the same cycle.
- R7: Writes to the live window or to addresses 12..15 change no state. Reads of addresses 12..15 return 0.
- R8: During and after reset, before any source changes, all live and change bits read 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_in | input | 32 | Live condition flags, asynchronous to clk |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A lost or phantom change bit shows up in two places: the change register of its group reads wrong, and `irq_n` disagrees with the enabled bits. Both appear one edge after the cycle in which the synchronized flag differed from its previous value. A synchronizer with the wrong depth shifts the live-window reads and the change-bit set by a whole cycle. This is caught on the first flag change, because the bench compares every read with a cycle-accurate model. A wrong precedence between set and clear only shows in a deliberate collision, so the bench forces one and reads the bit back.

// File: rtl/snb_pkg.sv
package snb_pkg;

   typedef enum logic [1:0] {
      RGN_LIVE   = 2'd0,
      RGN_CHANGE = 2'd1,
      RGN_ENABLE = 2'd2,
      RGN_NONE   = 2'd3
   } snb_region_e;

   // Window index for a flat register address, given registers per window.
   function automatic snb_region_e region_of(input int unsigned addr, input int unsigned ngrp);
      if (addr < ngrp)          return RGN_LIVE;
      else if (addr < 2 * ngrp) return RGN_CHANGE;
      else if (addr < 3 * ngrp) return RGN_ENABLE;
      else                      return RGN_NONE;
   endfunction

   // Offset of the address inside its window.
   function automatic int unsigned group_of(input int unsigned addr, input int unsigned ngrp);
      if (addr < 3 * ngrp) return addr % ngrp;
      else                 return 0;
   endfunction

endpackage

// File: rtl/snb_sync.sv
module snb_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/snb_change_grp.sv
module snb_change_grp #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] live,
   input  logic [W-1:0] clr_vec,
   output logic [W-1:0] change,
   output logic [W-1:0] toggle
);

   logic [W-1:0] prev;

   assign toggle = live ^ prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev   <= '0;
         change <= '0;
      end else begin
         prev   <= live;
         change <= (change & ~clr_vec) | toggle;
      end
   end

   AST_TOGGLE_SETS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (|toggle) |=> ((change & $past(toggle)) == $past(toggle))); // R2

   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (|(toggle & clr_vec)) |=> ((change & $past(toggle & clr_vec)) == $past(toggle & clr_vec))); // R4

   AST_CHANGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(change) & ~$past(clr_vec) & ~change) == '0)); // R3

   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_vec & ~toggle)) |=> ((change & $past(clr_vec & ~toggle)) == '0)); // R3

endmodule

// File: rtl/snb_enable_grp.sv
module snb_enable_grp #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] enable
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  enable <= '1;
      else if (wr) enable <= wdata;
   end

   AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(enable)); // R5

endmodule

// File: rtl/stat_notify_bank.sv
module stat_notify_bank
   import snb_pkg::*;
#(
   parameter int NUM_SRC     = 32,
   parameter int REG_W       = 8,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] status_in,
   input  logic               reg_wr,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [REG_W-1:0]   reg_wdata,
   output logic [REG_W-1:0]   reg_rdata,
   output logic               irq_n
);

   localparam int NGRP  = NUM_SRC / REG_W;
   localparam int GRP_W = (NGRP > 1) ? $clog2(NGRP) : 1;

   // Parameter guards
   if (NUM_SRC % REG_W != 0) begin : g_bad_split
      initial $fatal(1, "NUM_SRC must be a multiple of REG_W");
   end
   if ((1 << ADDR_W) < 3 * NGRP) begin : g_bad_addr
      initial $fatal(1, "ADDR_W too narrow for three register windows");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      initial $fatal(1, "SYNC_STAGES must be at least 2");
   end

   logic [NUM_SRC-1:0] live;
   logic [REG_W-1:0]   live_g   [NGRP];
   logic [REG_W-1:0]   change_g [NGRP];
   logic [REG_W-1:0]   enable_g [NGRP];
   logic [REG_W-1:0]   tog_g    [NGRP];
   logic [REG_W-1:0]   clr_g    [NGRP];
   logic               en_wr_g  [NGRP];
   snb_region_e        rgn;
   logic [GRP_W-1:0]   sel_grp;
   logic               tog_any;
   logic               hit;

   snb_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (status_in),
      .q     (live)
   );

   // Address decode
   always_comb begin
      rgn     = region_of(32'(reg_addr), NGRP);
      sel_grp = GRP_W'(group_of(32'(reg_addr), NGRP));
   end

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign live_g[g]  = live[g*REG_W +: REG_W];
      assign clr_g[g]   = (reg_wr && rgn == RGN_CHANGE && sel_grp == GRP_W'(g)) ? reg_wdata : '0;
      assign en_wr_g[g] = reg_wr && rgn == RGN_ENABLE && sel_grp == GRP_W'(g);

      snb_change_grp #(.W(REG_W)) u_chg (
         .clk     (clk),
         .rst_n   (rst_n),
         .live    (live_g[g]),
         .clr_vec (clr_g[g]),
         .change  (change_g[g]),
         .toggle  (tog_g[g])
      );

      snb_enable_grp #(.W(REG_W)) u_en (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr     (en_wr_g[g]),
         .wdata  (reg_wdata),
         .enable (enable_g[g])
      );
   end

   // Read path
   always_comb begin
      unique case (rgn)
         RGN_LIVE:   reg_rdata = live_g[sel_grp];
         RGN_CHANGE: reg_rdata = change_g[sel_grp];
         RGN_ENABLE: reg_rdata = enable_g[sel_grp];
         default:    reg_rdata = '0;
      endcase
   end

   // Interrupt
   always_comb begin
      hit     = 1'b0;
      tog_any = 1'b0;
      for (int g = 0; g < NGRP; g++) begin
         hit     = hit | (|(change_g[g] & enable_g[g]));
         tog_any = tog_any | (|tog_g[g]);
      end
      irq_n = ~hit;
   end

   AST_IRQ_RELEASE_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_n) |-> $past(reg_wr)); // R6

   AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_n) |-> ($past(tog_any) || $past(reg_wr))); // R6

   AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rgn == RGN_NONE) |-> (reg_rdata == '0)); // R7

endmodule

// File: tb/test_stat_notify_bank.sv
module test_stat_notify_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] status_in = '0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        irq_n;

   int checks = 0;
   int fails  = 0;

   // Reference model state
   logic [31:0] m_s1, m_s2, m_prev, m_chg, m_en;
   logic [31:0] st;

   always #5 clk = ~clk;

   stat_notify_bank i_stat_notify_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .status_in (status_in),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq_n     (irq_n)
   );

   // Model, built from the requirements
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_prev = '0; m_chg = '0; m_en = '1;
      end else begin
         logic [31:0] tog, clr;
         int a;
         a   = int'(reg_addr);
         tog = m_s2 ^ m_prev;
         clr = '0;
         if (reg_wr && a >= 4 && a < 8)  clr[(a-4)*8 +: 8] = reg_wdata;
         m_chg = (m_chg & ~clr) | tog;
         if (reg_wr && a >= 8 && a < 12) m_en[(a-8)*8 +: 8] = reg_wdata;
         m_prev = m_s2;
         m_s2   = m_s1;
         m_s1   = status_in;
      end
   end

   function automatic logic [7:0] exp_read(input int a);
      if (a < 4)       return m_s2[a*8 +: 8];
      else if (a < 8)  return m_chg[(a-4)*8 +: 8];
      else if (a < 12) return m_en[(a-8)*8 +: 8];
      else             return 8'h00;
   endfunction

   task automatic chk(input string tag);
      logic [7:0] e;
      logic       ei;
      e  = exp_read(int'(reg_addr));
      ei = ~|(m_chg & m_en);
      checks++;
      if (reg_rdata !== e) begin
         fails++;
         $display("FAIL %s addr=%0d rdata=%h expected=%h", tag, reg_addr, reg_rdata, e);
      end
      checks++;
      if (irq_n !== ei) begin
         fails++;
         $display("FAIL R6 (%s) irq_n=%b expected=%b", tag, irq_n, ei);
      end
   endtask

   task automatic cyc(input logic [3:0] a, input logic w, input logic [7:0] d, input string tag);
      @(negedge clk);
      reg_addr  = a;
      reg_wr    = w;
      reg_wdata = d;
      status_in = st;
      #1;
      chk(tag);
   endtask

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'd7741);
      st = '0;
      repeat (3) @(negedge clk);
      #1;
      chk("R8 in reset");
      @(negedge clk);
      rst_n = 1'b1;
      // R8 / R5 / R7: reset image of every address
      for (int a = 0; a < 16; a++) cyc(4'(a), 1'b0, 8'h00, "R8 R5 R7 reset image");

      // R1: rising flag appears in live window after two edges
      st[0] = 1'b1;
      cyc(4'd0, 1'b0, 8'h00, "R1 live before sync");
      cyc(4'd0, 1'b0, 8'h00, "R1 live mid sync");
      cyc(4'd0, 1'b0, 8'h00, "R1 live after sync");
      cyc(4'd4, 1'b0, 8'h00, "R2 rising change");
      cyc(4'd4, 1'b0, 8'h00, "R2 change held");
      // R3: writing 0 keeps, writing 1 clears
      cyc(4'd4, 1'b1, 8'h00, "R3 write zero");
      cyc(4'd4, 1'b0, 8'h00, "R3 still set");
      cyc(4'd4, 1'b1, 8'h01, "R3 write one");
      cyc(4'd4, 1'b0, 8'h00, "R3 cleared");
      // R2: falling edge also sets
      st[0] = 1'b0;
      repeat (3) cyc(4'd4, 1'b0, 8'h00, "R2 falling wait");
      cyc(4'd4, 1'b0, 8'h00, "R2 falling change");
      // R5 / R6: disable source 0, interrupt releases while bit stays
      cyc(4'd8, 1'b1, 8'hFE, "R5 enable write");
      cyc(4'd8, 1'b0, 8'h00, "R5 enable readback");
      cyc(4'd4, 1'b0, 8'h00, "R6 masked pending");
      cyc(4'd8, 1'b1, 8'hFF, "R5 enable restore");
      cyc(4'd4, 1'b0, 8'h00, "R6 unmasked pending");
      cyc(4'd4, 1'b1, 8'hFF, "R3 clear group0");
      cyc(4'd4, 1'b0, 8'h00, "R6 released");

      // R4: collision of change and clear on source 9
      st[9] = 1'b1;
      cyc(4'd5, 1'b0, 8'h00, "R4 setup");
      cyc(4'd5, 1'b0, 8'h00, "R4 toggle cycle");
      cyc(4'd5, 1'b1, 8'h02, "R4 clear at set");
      cyc(4'd5, 1'b0, 8'h00, "R4 set wins");
      cyc(4'd5, 1'b1, 8'h02, "R4 cleanup");
      cyc(4'd5, 1'b0, 8'h00, "R4 cleared after");

      // R7: writes to live window and unmapped space ignored
      cyc(4'd1, 1'b1, 8'hA5, "R7 live write");
      cyc(4'd1, 1'b0, 8'h00, "R7 live unchanged");
      cyc(4'd5, 1'b0, 8'h00, "R7 change unchanged");
      cyc(4'd13, 1'b1, 8'h5A, "R7 unmapped write");
      for (int a = 0; a < 16; a++) cyc(4'(a), 1'b0, 8'h00, "R7 image after");

      // Mixed random traffic against the model
      for (int i = 0; i < 800; i++) begin
         logic [3:0] a;
         logic       w;
         if ($urandom % 3 == 0) st[$urandom % 32] ^= 1'b1;
         a = 4'($urandom % 16);
         w = ($urandom % 3 == 0);
         cyc(a, w, 8'($urandom), "R2/R3/R5 random");
      end

      summary();
      $finish;
   end

endmodule